// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block programs an SRAM-based programmable device through a passive-serial configuration link. A client pulses `start_i` and then streams the bitstream one byte at a time over a ready/valid input. The loader first switches the target's supply on through an active-low power-enable line. It then holds the target's active-low configuration reset low for a timed interval and releases it. After that it shifts each byte onto the data line, least significant bit first, with one configuration clock per bit. The configuration clock runs at half the system clock.

When the byte marked `in_last_i` has been shifted, the loader sends a fixed run of extra clocks with the data line held at zero. It then reads the two status inputs from the target. One is configuration-done. The other is an active-low status line, which reads high when there is no error. The result appears as a one-cycle completion pulse with an error flag and the sampled 2-bit status. Only one load can run at a time. Power stays enabled after the first load until the block's own reset.

Top module: `ps_cfg_loader`

## Requirements
- R1: After `rst_ni` is deasserted and before any start, the outputs read `pwr_en_no`=1, `cfg_rst_no`=1, `cfg_clk_o`=0, `cfg_data_o`=0, `in_ready_o`=0, `busy_o`=0 and `done_o`=0.
- R2: A start accepted while idle drives `pwr_en_no` low. It stays low until `rst_ni` is asserted, and it is already low in every cycle in which `cfg_rst_no` is low.
- R3: After an accepted start, `cfg_rst_no` is low for exactly RST_CYCLES = CLK_HZ/1_000_000*RST_US system cycles and then returns high. `cfg_clk_o` stays low while `cfg_rst_no` is low.
- R4: Each accepted byte produces exactly 8 rising edges of `cfg_clk_o`. Bit 0 is presented first and bit 7 last. `cfg_clk_o` is high for one system cycle and low for one system cycle, and `cfg_data_o` is stable across each rising edge.
- R5: After the byte accepted with `in_last_i`=1, exactly FLUSH_CLKS (default 50) further rising edges of `cfg_clk_o` occur, each with `cfg_data_o`=0.
- R6: When the flush ends, `done_o` is high for exactly one cycle. In that cycle `status_o` = {configuration-done, active-low status}, with bit 1 taken from `conf_done_i` and bit 0 from `status_ni`. `error_o` is 1 unless `status_o` is 2'b11, and it is never high without `done_o`.
- R7: `start_i` while a load is in progress is ignored. It does not cause a second reset pulse, and the bit stream of the current load is unchanged.
- R8: `in_ready_o` is high only during the data phase when no byte is being shifted. Bytes offered while idle are not taken and produce no configuration clocks.
- R9: `busy_o` is high from the cycle after an accepted start until the load completes. It is low in the cycle where `done_o` is high, and a new start is accepted from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a load (taken only when idle) |
| in_valid_i | input | 1 | Bitstream byte valid |
| in_data_i | input | 8 | Bitstream byte |
| in_last_i | input | 1 | Marks the final byte of the bitstream |
| in_ready_o | output | 1 | Loader can accept a byte |
| busy_o | output | 1 | Load in progress |
| pwr_en_no | output | 1 | Active-low target power enable |
| cfg_rst_no | output | 1 | Active-low target configuration reset |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 1 | Configuration serial data |
| conf_done_i | input | 1 | Target configuration-done |
| status_ni | input | 1 | Target active-low status |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Load failed (valid with done_o) |
| status_o | output | 2 | Sampled {configuration-done, active-low status} |

## Verification
The assertions check every cycle for the following. Power is on whenever the reset line is low. No clock edge occurs while reset is held. Data is stable across each clock rise. The reset pulse has exactly the programmed length. Completion is a single-cycle pulse, and the error flag matches the reported status. A reset pulse only begins from idle. Only the bench scenarios can show the order of the bits, the byte-to-clock count, the length of the zero flush after the last byte, the status mapping for each combination of the two inputs, and that starts or bytes offered at the wrong time leave the stream untouched.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RST   = 2'd1,
    ST_LOAD  = 2'd2,
    ST_FLUSH = 2'd3
  } ps_state_e;

  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/ps_cfg_rst_timer.sv
module ps_cfg_rst_timer #(
  parameter int unsigned CYCLES = 200,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ps_cfg_serializer.sv
module ps_cfg_serializer
  import ps_cfg_pkg::*;
#(
  parameter int unsigned FLUSH_CLKS = 50,
  localparam int unsigned MAX_BITS = (FLUSH_CLKS > BYTE_BITS) ? FLUSH_CLKS : BYTE_BITS,
  localparam int unsigned REM_W = $clog2(MAX_BITS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_byte_i,
  input  logic       load_zero_i,
  input  logic [7:0] byte_i,
  output logic       idle_o,
  output logic       cfg_clk_o,
  output logic       cfg_data_o
);
  logic [7:0]       shreg_q;
  logic [REM_W-1:0] rem_q;
  logic             hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      rem_q   <= '0;
      hi_q    <= 1'b0;
    end else if (rem_q == '0) begin
      hi_q <= 1'b0;
      if (load_byte_i) begin
        shreg_q <= byte_i;
        rem_q   <= REM_W'(BYTE_BITS);
      end else if (load_zero_i) begin
        shreg_q <= '0;
        rem_q   <= REM_W'(FLUSH_CLKS);
      end
    end else if (!hi_q) begin
      hi_q <= 1'b1;
    end else begin
      // falling edge: advance to next bit
      hi_q    <= 1'b0;
      shreg_q <= {1'b0, shreg_q[7:1]};
      rem_q   <= rem_q - REM_W'(1);
    end
  end

  assign idle_o     = (rem_q == '0);
  assign cfg_clk_o  = hi_q;
  assign cfg_data_o = shreg_q[0];
endmodule

// File: rtl/ps_cfg_status_sync.sv
module ps_cfg_status_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       in_valid_i,
  input  logic       in_last_i,
  input  logic       tmr_zero_i,
  input  logic       ser_idle_i,
  input  logic [1:0] status_i,
  output logic       tmr_start_o,
  output logic       ser_load_byte_o,
  output logic       ser_load_zero_o,
  output logic       in_ready_o,
  output logic       busy_o,
  output logic       pwr_en_no,
  output logic       done_o,
  output logic       error_o,
  output logic [1:0] status_o
);
  ps_state_e state_q, state_d;
  logic      last_q;
  logic      pwr_q;
  logic      done_q, err_q;
  logic [1:0] stat_q;
  logic      finish;

  assign tmr_start_o     = (state_q == ST_IDLE) && start_i;
  assign in_ready_o      = (state_q == ST_LOAD) && ser_idle_i && !last_q;
  assign ser_load_byte_o = in_ready_o && in_valid_i;
  assign ser_load_zero_o = (state_q == ST_LOAD) && ser_idle_i && last_q;
  assign finish          = (state_q == ST_FLUSH) && ser_idle_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)         state_d = ST_RST;
      ST_RST:   if (tmr_zero_i)      state_d = ST_LOAD;
      ST_LOAD:  if (ser_load_zero_o) state_d = ST_FLUSH;
      ST_FLUSH: if (finish)          state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
      pwr_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      err_q   <= finish && (status_i != 2'b11);
      if (tmr_start_o)                    pwr_q  <= 1'b1;
      if (ser_load_byte_o && in_last_i)   last_q <= 1'b1;
      else if (ser_load_zero_o)           last_q <= 1'b0;
      if (finish)                         stat_q <= status_i;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign pwr_en_no = ~pwr_q;
  assign done_o    = done_q;
  assign error_o   = err_q;
  assign status_o  = stat_q;
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned RST_US     = 200,
  parameter int unsigned FLUSH_CLKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic       busy_o,
  output logic       pwr_en_no,
  output logic       cfg_rst_no,
  output logic       cfg_clk_o,
  output logic       cfg_data_o,
  input  logic       conf_done_i,
  input  logic       status_ni,
  output logic       done_o,
  output logic       error_o,
  output logic [1:0] status_o
);
  localparam int unsigned RST_CYCLES = (CLK_HZ / 1_000_000) * RST_US;

  logic       tmr_start, tmr_zero;
  logic       ser_idle, ser_load_byte, ser_load_zero;
  logic [1:0] status_sync;

  ps_cfg_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .zero_o (tmr_zero)
  );

  assign cfg_rst_no = tmr_zero;

  ps_cfg_serializer #(.FLUSH_CLKS(FLUSH_CLKS)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_byte_i(ser_load_byte),
    .load_zero_i(ser_load_zero),
    .byte_i     (in_data_i),
    .idle_o     (ser_idle),
    .cfg_clk_o  (cfg_clk_o),
    .cfg_data_o (cfg_data_o)
  );

  ps_cfg_status_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({conf_done_i, status_ni}),
    .sync_o (status_sync)
  );

  ps_cfg_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .in_valid_i     (in_valid_i),
    .in_last_i      (in_last_i),
    .tmr_zero_i     (tmr_zero),
    .ser_idle_i     (ser_idle),
    .status_i       (status_sync),
    .tmr_start_o    (tmr_start),
    .ser_load_byte_o(ser_load_byte),
    .ser_load_zero_o(ser_load_zero),
    .in_ready_o     (in_ready_o),
    .busy_o         (busy_o),
    .pwr_en_no      (pwr_en_no),
    .done_o         (done_o),
    .error_o        (error_o),
    .status_o       (status_o)
  );
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk #(
  parameter int unsigned RST_CYCLES = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       busy_o,
  input logic       pwr_en_no,
  input logic       cfg_rst_no,
  input logic       cfg_clk_o,
  input logic       cfg_data_o,
  input logic       done_o,
  input logic       error_o,
  input logic [1:0] status_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= 0;
    else if (!cfg_rst_no) low_cnt <= low_cnt + 1;
    else                  low_cnt <= 0;
  end

  // R2
  pwr_before_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rst_no |-> !pwr_en_no);

  // R3
  rst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_rst_no) |-> (low_cnt == RST_CYCLES));

  // R3
  no_clk_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rst_no |-> !cfg_clk_o);

  // R4
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_clk_o) |-> $stable(cfg_data_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  // R6
  err_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (error_o == (status_o != 2'b11)));

  // R7
  rst_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_rst_no) |-> !$past(busy_o));

  // R8
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (busy_o && cfg_rst_no && !cfg_clk_o));

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind ps_cfg_loader ps_cfg_loader_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/ps_cfg_loader_tb.sv
module ps_cfg_loader_tb;
  localparam int unsigned CLK_HZ     = 1_000_000;
  localparam int unsigned RST_US     = 200;
  localparam int unsigned FLUSH_CLKS = 50;
  localparam int unsigned EXP_RST    = (CLK_HZ / 1_000_000) * RST_US;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_last_i = 1'b0;
  logic       conf_done_i = 1'b0;
  logic       status_ni = 1'b0;
  logic       in_ready_o, busy_o, pwr_en_no, cfg_rst_no, cfg_clk_o, cfg_data_o;
  logic       done_o, error_o;
  logic [1:0] status_o;

  int checks = 0;
  int failures = 0;

  ps_cfg_loader #(.CLK_HZ(CLK_HZ), .RST_US(RST_US), .FLUSH_CLKS(FLUSH_CLKS)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  // monitor
  logic bits_cap [4096];
  int   cap_n = 0;
  int   rst_low = 0;
  int   rst_falls = 0;
  int   pwr_bad = 0;
  logic prev_clk = 1'b0;
  logic prev_rst = 1'b1;

  always @(negedge clk_i) begin
    if (cfg_clk_o && !prev_clk && cap_n < 4096) begin
      bits_cap[cap_n] = cfg_data_o;
      cap_n++;
    end
    if (!cfg_rst_no) rst_low++;
    if (!cfg_rst_no && prev_rst) rst_falls++;
    if (!cfg_rst_no && pwr_en_no) pwr_bad++;
    prev_clk = cfg_clk_o;
    prev_rst = cfg_rst_no;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic [1:0] st);
    return st != 2'b11;
  endfunction

  task automatic run_load(input int n, input logic [7:0] fixed, input logic use_fixed,
                          input logic [1:0] st, input logic busy_start);
    logic [7:0] data [16];
    int base_bits, base_low, base_falls, i, k, waitc;
    logic ok;
    for (int b = 0; b < n; b++) data[b] = use_fixed ? fixed : 8'($urandom);
    conf_done_i = st[1];
    status_ni   = st[0];
    base_bits = cap_n; base_low = rst_low; base_falls = rst_falls;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    check("R9 busy after start", busy_o, 1);
    check("R2 power on", pwr_en_no, 0);
    if (busy_start) begin
      repeat (7) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
    end
    i = 0;
    while (i < n) begin
      @(negedge clk_i);
      if ($urandom % 4 == 0) begin
        in_valid_i = 1'b0;
      end else begin
        in_valid_i = 1'b1;
        in_data_i  = data[i];
        in_last_i  = (i == n-1);
        if (in_ready_o) begin
          @(posedge clk_i);
          i++;
        end
      end
    end
    @(negedge clk_i) begin in_valid_i = 1'b0; in_last_i = 1'b0; end
    waitc = 0;
    while (!done_o && waitc < 5000) begin @(negedge clk_i); waitc++; end
    #1;
    check("R6 done seen", done_o, 1);
    check("R6 error flag", error_o, exp_err(st));
    check("R6 status", status_o, st);
    check("R9 idle at done", busy_o, 0);
    check("R3 reset length", rst_low - base_low, EXP_RST);
    check("R7 one reset pulse", rst_falls - base_falls, 1);
    check("R4 R5 clock count", cap_n - base_bits, n*8 + FLUSH_CLKS);
    ok = 1'b1;
    k = base_bits;
    for (int b = 0; b < n; b++)
      for (int j = 0; j < 8; j++) begin
        if (bits_cap[k] !== data[b][j]) ok = 1'b0;
        k++;
      end
    check("R4 bits LSB first", ok, 1);
    ok = 1'b1;
    for (int f = 0; f < FLUSH_CLKS; f++) if (bits_cap[k+f] !== 1'b0) ok = 1'b0;
    check("R5 flush zeros", ok, 1);
    @(negedge clk_i);
    check("R6 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    logic saw_ready;
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check("R1 pwr", pwr_en_no, 1);
    check("R1 rst", cfg_rst_no, 1);
    check("R1 clk", cfg_clk_o, 0);
    check("R1 data", cfg_data_o, 0);
    check("R1 ready", in_ready_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    // R8: bytes while idle
    c0 = cap_n; saw_ready = 1'b0;
    in_valid_i = 1'b1; in_data_i = 8'hA5; in_last_i = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk_i);
      if (in_ready_o) saw_ready = 1'b1;
    end
    in_valid_i = 1'b0; in_last_i = 1'b0;
    check("R8 no ready when idle", saw_ready, 0);
    check("R8 no clocks when idle", cap_n - c0, 0);
    // directed corners
    run_load(1, 8'h01, 1'b1, 2'b11, 1'b0);
    run_load(1, 8'h80, 1'b1, 2'b10, 1'b0);
    run_load(2, 8'hFF, 1'b1, 2'b01, 1'b0);
    run_load(3, 8'h00, 1'b0, 2'b00, 1'b1);   // R7 start while busy
    // random
    for (int r = 0; r < 8; r++)
      run_load(1 + int'($urandom % 8), 8'h00, 1'b0, 2'($urandom), (r % 3) == 0);
    check("R2 power held", pwr_en_no, 0);
    check("R2 power during reset", pwr_bad, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule